// File: doc/BRIEF.md
# Processor Control Register File

This block keeps the system control state of a small 32-bit CPU model. There are four register slots, selected by a 2-bit index:

- **Slot 0, control word.** Holds the protection enable, the paging enable and four coprocessor control flags.
- **Slot 1, reserved.** It holds nothing, and any access to it traps.
- **Slot 2, fault address.** Holds the linear address of the most recent page fault.
- **Slot 3, directory base.** Holds a page-aligned page-directory base address.

Software reaches the slots through a single access port. A read returns data in the same cycle. A write takes effect at the next clock edge.

The exception outputs for an access are combinational and valid in the same cycle as the request. The same is true of the trap decisions for floating-point and WAIT instructions, which the pipeline reports through two dispatch strobes. Other units drive three event inputs: a page fault capture, a task switch that marks the coprocessor state as stale, and a task-switch load of the directory base. The block drives a one-cycle translation-cache flush pulse. That pulse is asserted on the clock cycle after every software write of the directory base. After a task-switch load it is asserted only when the loaded base differs from the current one.

Top module: `ctrl_regfile`

## Requirements
- R1: While `rst_n` is low, every register clears and the ET flag (control word bit 4) takes the value of `cop_type`. After reset, slot 0 therefore reads `{27'b0, cop_type, 4'b0}`, slots 2 and 3 read 0, and `prot_en`, `paging_en` and `tlb_flush` are 0.
- R2: A legal write to slot 0 stores these bits: bit 0 (protection, driving `prot_en`), bit 1 (MP), bit 2 (EM), bit 3 (TS) and bit 31 (paging, driving `paging_en`). Bits 5 to 30 always read 0. Bit 4 (ET) ignores writes.
- R3: A write to slot 0 with bit 31 = 1 and bit 0 = 0 raises `gp_fault` in that cycle and leaves the control word unchanged. Because of this, `paging_en` never rises while `prot_en` is 0.
- R4: Any read or write of slot 1 raises `ud_fault`, changes no state and reads 0. For that access `gp_fault` stays low, whatever the write data.
- R5: A `task_switch` pulse sets TS. The pulse wins over a write of TS = 0 in the same cycle.
- R6: With `fp_op` high, the result depends on EM and TS. When EM = 1, `emu_trap` is raised and `dna_trap` is not. When EM = 0 and TS = 1, `dna_trap` is raised. When both are 0, neither trap is raised.
- R7: With `wait_op` high, `dna_trap` is raised exactly when MP = 1 and TS = 1. EM has no effect on this decision.
- R8: A `fault_addr_valid` pulse loads `fault_addr` into slot 2. It takes priority over a software write to slot 2 in the same cycle.
- R9: Slot 3 always holds and reads 0 in its low `PAGE_BITS` bits, for both software writes and task-switch loads.
- R10: Every software write to slot 3 makes `tlb_flush` high for exactly the following cycle. This holds in any mode, including with protection and paging off.
- R11: A `task_pdbr_load` pulse loads the aligned `task_pdbr` into slot 3 and takes priority over a software write in the same cycle. It flushes only when the aligned new value differs from the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cop_type | input | 1 | Coprocessor type strap sampled into ET during reset |
| acc_valid | input | 1 | Register access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 2 | Register slot index |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data of the selected slot |
| gp_fault | output | 1 | Illegal paging/protection write |
| ud_fault | output | 1 | Reserved slot access |
| fault_addr_valid | input | 1 | Page fault capture strobe |
| fault_addr | input | 32 | Faulting linear address |
| task_switch | input | 1 | Task switch event, sets TS |
| task_pdbr_load | input | 1 | Task-switch load of the directory base |
| task_pdbr | input | 32 | New directory base from the task |
| fp_op | input | 1 | Floating-point instruction dispatch |
| wait_op | input | 1 | WAIT instruction dispatch |
| dna_trap | output | 1 | Device-not-available trap |
| emu_trap | output | 1 | Emulation trap |
| prot_en | output | 1 | Protected mode active |
| paging_en | output | 1 | Paging active |
| tlb_flush | output | 1 | Translation cache flush pulse |

## Verification
The bench builds the block with the default `PAGE_BITS` of 12. This exercises the 4 KiB alignment mask on the directory base, which has to take effect on both the software and the task-switch load paths. Random directory values mostly have nonzero low bits, so the alignment is tested on nearly every load. Task-switch loads that repeat the stored base reach the no-flush branch. Events that coincide with software writes exercise the TS, fault-address and directory-base priority rules.

// File: rtl/ctrl_regfile.sv
module ctrl_regfile #(
  parameter int PAGE_BITS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cop_type,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [1:0]  acc_idx,
  input  logic [31:0] acc_wdata,
  output logic [31:0] acc_rdata,
  output logic        gp_fault,
  output logic        ud_fault,
  input  logic        fault_addr_valid,
  input  logic [31:0] fault_addr,
  input  logic        task_switch,
  input  logic        task_pdbr_load,
  input  logic [31:0] task_pdbr,
  input  logic        fp_op,
  input  logic        wait_op,
  output logic        dna_trap,
  output logic        emu_trap,
  output logic        prot_en,
  output logic        paging_en,
  output logic        tlb_flush
);
  localparam logic [31:0] BASE_MASK = ~((32'd1 << PAGE_BITS) - 32'd1);

  logic pe, mp, em, ts, et, pg;
  logic [31:0] fault_lin, pdbr;
  logic unused_bits;

  wire wr      = acc_valid & acc_write;
  wire cw_wr   = wr & (acc_idx == 2'd0);
  wire cw_ok   = cw_wr & ~gp_fault;
  wire fa_wr   = wr & (acc_idx == 2'd2);
  wire db_wr   = wr & (acc_idx == 2'd3);
  wire [31:0] task_base = task_pdbr & BASE_MASK;

  assign unused_bits = ^acc_wdata[30:4];
  assign ud_fault  = acc_valid & (acc_idx == 2'd1);
  assign gp_fault  = cw_wr & acc_wdata[31] & ~acc_wdata[0];
  assign emu_trap  = fp_op & em;
  assign dna_trap  = (fp_op & ~em & ts) | (wait_op & mp & ts);
  assign prot_en   = pe;
  assign paging_en = pg;

  always_comb begin
    case (acc_idx)
      2'd0:    acc_rdata = {pg, 26'd0, et, ts, em, mp, pe};
      2'd2:    acc_rdata = fault_lin;
      2'd3:    acc_rdata = pdbr;
      default: acc_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {pe, mp, em, ts, pg} <= '0;
      et        <= cop_type;
      fault_lin <= '0;
      pdbr      <= '0;
      tlb_flush <= 1'b0;
    end else begin
      if (cw_ok) begin
        pe <= acc_wdata[0];
        mp <= acc_wdata[1];
        em <= acc_wdata[2];
        pg <= acc_wdata[31];
      end
      ts <= task_switch | (cw_ok ? acc_wdata[3] : ts);
      if (fault_addr_valid) fault_lin <= fault_addr;
      else if (fa_wr)       fault_lin <= acc_wdata;
      if (task_pdbr_load)   pdbr <= task_base;
      else if (db_wr)       pdbr <= acc_wdata & BASE_MASK;
      tlb_flush <= db_wr | (task_pdbr_load & (task_base != pdbr));
    end
  end
endmodule

// File: rtl/ctrl_regfile_chk.sv
module ctrl_regfile_chk #(
  parameter int PAGE_BITS = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [1:0]  acc_idx,
  input logic        gp_fault,
  input logic        ud_fault,
  input logic        fault_addr_valid,
  input logic [31:0] fault_addr,
  input logic [31:0] fault_lin,
  input logic        task_switch,
  input logic        ts,
  input logic        em,
  input logic        mp,
  input logic        fp_op,
  input logic        wait_op,
  input logic        dna_trap,
  input logic        emu_trap,
  input logic        prot_en,
  input logic        paging_en,
  input logic [31:0] pdbr,
  input logic        tlb_flush
);
  assert_paging_needs_prot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    paging_en |-> prot_en);
  assert_gp_keeps_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |=> (prot_en == $past(prot_en) && paging_en == $past(paging_en)));
  assert_reserved_traps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_idx == 2'd1) |-> (ud_fault && !gp_fault));
  assert_ts_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    task_switch |=> ts);
  assert_emu_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_op && !wait_op && em) |-> (emu_trap && !dna_trap));
  assert_wait_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_op && !fp_op && !(mp && ts)) |-> !dna_trap);
  assert_fault_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_addr_valid |=> (fault_lin == $past(fault_addr)));
  assert_base_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pdbr[PAGE_BITS-1:0] == '0);
  assert_write_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_idx == 2'd3) |=> tlb_flush);
endmodule

bind ctrl_regfile ctrl_regfile_chk #(.PAGE_BITS(PAGE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_idx(acc_idx), .gp_fault(gp_fault), .ud_fault(ud_fault),
  .fault_addr_valid(fault_addr_valid), .fault_addr(fault_addr),
  .fault_lin(fault_lin), .task_switch(task_switch), .ts(ts), .em(em), .mp(mp),
  .fp_op(fp_op), .wait_op(wait_op), .dna_trap(dna_trap), .emu_trap(emu_trap),
  .prot_en(prot_en), .paging_en(paging_en), .pdbr(pdbr), .tlb_flush(tlb_flush)
);

// File: tb/tb_ctrl_regfile.sv
module tb_ctrl_regfile;
  localparam int PAGE_BITS = 12;
  localparam logic [31:0] MASK = ~((32'd1 << PAGE_BITS) - 32'd1);

  logic clk = 1'b0, rst_n = 1'b0, cop_type = 1'b1;
  logic acc_valid = 0, acc_write = 0, fault_addr_valid = 0, task_switch = 0;
  logic task_pdbr_load = 0, fp_op = 0, wait_op = 0;
  logic [1:0]  acc_idx = 0;
  logic [31:0] acc_wdata = 0, fault_addr = 0, task_pdbr = 0;
  logic [31:0] acc_rdata;
  logic gp_fault, ud_fault, dna_trap, emu_trap, prot_en, paging_en, tlb_flush;

  int checks = 0, errors = 0;
  logic mpe, mmp, mem, mts, met, mpg, mflush;
  logic [31:0] mcr2, mcr3;

  always #10 clk = ~clk;

  ctrl_regfile #(.PAGE_BITS(PAGE_BITS)) dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [1:0] idx);
    case (idx)
      2'd0: return {mpg, 26'd0, met, mts, mem, mmp, mpe};
      2'd2: return mcr2;
      2'd3: return mcr3;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_dna();
    return (fp_op & ~mem & mts) | (wait_op & mmp & mts);
  endfunction

  task automatic clear_inputs();
    acc_valid = 0; acc_write = 0; fault_addr_valid = 0; task_switch = 0;
    task_pdbr_load = 0; fp_op = 0; wait_op = 0;
  endtask

  // Called at a falling edge with inputs already driven.
  task automatic step();
    logic wr, gp, cw_ok, db_wr;
    #1;
    wr = acc_valid & acc_write;
    gp = wr & (acc_idx == 0) & acc_wdata[31] & ~acc_wdata[0];
    check(gp_fault === gp, "R3", {31'd0, gp_fault}, {31'd0, gp});
    check(ud_fault === (acc_valid & (acc_idx == 1)), "R4", {31'd0, ud_fault}, {31'd0, acc_valid & (acc_idx == 1)});
    if (acc_valid && !acc_write)
      check(acc_rdata === exp_read(acc_idx), "R2", acc_rdata, exp_read(acc_idx));
    check(emu_trap === (fp_op & mem), "R6", {31'd0, emu_trap}, {31'd0, fp_op & mem});
    check(dna_trap === exp_dna(), "R7", {31'd0, dna_trap}, {31'd0, exp_dna()});
    @(posedge clk);
    cw_ok = wr & (acc_idx == 0) & ~gp;
    db_wr = wr & (acc_idx == 3);
    if (cw_ok) begin mpe = acc_wdata[0]; mmp = acc_wdata[1]; mem = acc_wdata[2]; mpg = acc_wdata[31]; end
    mts = task_switch | (cw_ok ? acc_wdata[3] : mts);
    if (fault_addr_valid) mcr2 = fault_addr;
    else if (wr && acc_idx == 2) mcr2 = acc_wdata;
    mflush = db_wr | (task_pdbr_load & ((task_pdbr & MASK) != mcr3));
    if (task_pdbr_load) mcr3 = task_pdbr & MASK;
    else if (db_wr) mcr3 = acc_wdata & MASK;
    @(negedge clk);
    check(tlb_flush === mflush, "R10/R11", {31'd0, tlb_flush}, {31'd0, mflush});
    check(prot_en === mpe && paging_en === mpg, "R2", {30'd0, paging_en, prot_en}, {30'd0, mpg, mpe});
    clear_inputs();
  endtask

  task automatic wr_reg(input logic [1:0] idx, input logic [31:0] d);
    acc_valid = 1; acc_write = 1; acc_idx = idx; acc_wdata = d; step();
  endtask

  task automatic rd_reg(input logic [1:0] idx, output logic [31:0] d);
    acc_valid = 1; acc_write = 0; acc_idx = idx; #1; d = acc_rdata; #0; step();
  endtask

  task automatic do_reset(input logic ct);
    rst_n = 0; cop_type = ct;
    repeat (2) @(negedge clk);
    rst_n = 1;
    mpe = 0; mmp = 0; mem = 0; mts = 0; mpg = 0; met = ct; mcr2 = 0; mcr3 = 0; mflush = 0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    clear_inputs();
    do_reset(1'b1);
    // R1 reset state
    rd_reg(2'd0, d); check(d === 32'h10, "R1", d, 32'h10);
    rd_reg(2'd3, d); check(d === 0, "R1", d, 0);
    check(tlb_flush === 0 && prot_en === 0, "R1", {31'd0, tlb_flush}, 0);
    // R2 legal write, reserved bits and ET
    wr_reg(2'd0, 32'hFFFF_FFEF);
    rd_reg(2'd0, d); check(d === 32'h8000_001F, "R2", d, 32'h8000_001F);
    // R3 illegal combination
    wr_reg(2'd0, 32'h8000_0000);
    rd_reg(2'd0, d); check(d === 32'h8000_001F, "R3", d, 32'h8000_001F);
    // R4 reserved slot write with illegal pattern
    wr_reg(2'd1, 32'h8000_0000);
    rd_reg(2'd1, d); check(d === 0, "R4", d, 0);
    // R6/R7 dispatch with EM=1, MP=1, TS=1
    fp_op = 1; step(); wait_op = 1; step();
    wr_reg(2'd0, 32'h0000_0009);               // PE, TS, EM=0, MP=0
    fp_op = 1; step(); wait_op = 1; step();     // R6 dna, R7 quiet
    // R5 task switch beats TS clear
    task_switch = 1; acc_valid = 1; acc_write = 1; acc_idx = 0; acc_wdata = 32'h1; step();
    rd_reg(2'd0, d); check(d[3] === 1'b1, "R5", d, 32'h19);
    // R10 flush in real mode
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd3, 32'h1234_5FFF);
    rd_reg(2'd3, d); check(d === 32'h1234_5000, "R9", d, 32'h1234_5000);
    // R11 same base: no flush; different base: flush
    task_pdbr_load = 1; task_pdbr = 32'h1234_5ABC; step();
    check(tlb_flush === 0, "R11", {31'd0, tlb_flush}, 0);
    task_pdbr_load = 1; task_pdbr = 32'h0ABC_D123; acc_valid = 1; acc_write = 1; acc_idx = 3; acc_wdata = 32'h5555_5000; step();
    rd_reg(2'd3, d); check(d === 32'h0ABC_D000, "R11", d, 32'h0ABC_D000);
    // R8 fault capture beats software write
    fault_addr_valid = 1; fault_addr = 32'hDEAD_BEEF; acc_valid = 1; acc_write = 1; acc_idx = 2; acc_wdata = 32'h1; step();
    rd_reg(2'd2, d); check(d === 32'hDEAD_BEEF, "R8", d, 32'hDEAD_BEEF);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      acc_valid = ($urandom % 4) != 0;
      acc_write = $urandom % 2;
      acc_idx = 2'($urandom);
      acc_wdata = $urandom;
      if ($urandom % 3 == 0) acc_wdata[0] = 1'b1;
      fault_addr_valid = ($urandom % 8) == 0; fault_addr = $urandom;
      task_switch = ($urandom % 8) == 0;
      task_pdbr_load = ($urandom % 8) == 0;
      task_pdbr = ($urandom % 2) ? (mcr3 | 32'($urandom % 4096)) : $urandom;
      fp_op = $urandom % 2; wait_op = $urandom % 2;
      step();
    end
    // R1 reset with the older coprocessor type
    do_reset(1'b0);
    rd_reg(2'd0, d); check(d === 0, "R1", d, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule